// File: doc/BRIEF.md
# Triple-Redundant Clock Domain Synchronizer

This block carries a multi-bit level signal from a foreign clock domain into a capture clock domain inside a design hardened by triple modular redundancy. Each bit passes through a chain of flip-flops clocked by the capture clock. The first flip-flop in the chain may go metastable. The later flip-flops give it time to settle before any downstream logic sees the value. The chain is a plain shift path: no gate and no voter sits between two of its flip-flops, because any delay there reduces the settling slack.

A topology parameter chooses where the redundancy starts. In block mode, a single chain synchronizes the signal and its output fans out to three redundant consumers. In distributed mode, the chain itself is triplicated and a bitwise majority vote is taken only after the last stage of each chain. In both modes, the block produces three voted copies and a registered flag that reports any disagreement among the three final-stage values, so the flag serves as an upset monitor.

Top module: `tmr_cdc_sync`

## Requirements
- R1: On each rising edge of `clk_i`, the first stage samples `data_i`. A change of `data_i` that starts and ends between two rising edges leaves the outputs unchanged.
- R2: After `data_i` changes and then holds steady, the outputs still show the old value after STAGES-1 rising edges and show the new value after exactly STAGES rising edges.
- R3: Each stage after the first loads the previous stage's output directly, with no logic in between.
- R4: With TOPO = TOPO_BLOCK, one chain feeds all three voted outputs. All three outputs then show the same value with a latency of STAGES edges.
- R5: With TOPO = TOPO_DIST, three independent chains run in parallel, and voting happens only after their final stages.
- R6: Each output bit is the majority of the three final-stage bits, (x&y)|(y&z)|(x&z). A single wrong copy is masked, and two wrong copies that agree win the vote.
- R7: `mismatch_o` is 1 in the cycle that follows a rising edge at which the three final-stage values differed in any bit. Otherwise it is 0.
- R8: While `rst_ni` is low, every stage holds RST_VAL at once, without waiting for a clock edge, and `mismatch_o` is 0.
- R9: A STAGES value below 2 stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset; released in step with `clk_i` |
| data_i | input | WIDTH | Level signal launched from the source domain |
| sync_a_o | output | WIDTH | Voted synchronized copy A |
| sync_b_o | output | WIDTH | Voted synchronized copy B |
| sync_c_o | output | WIDTH | Voted synchronized copy C |
| mismatch_o | output | 1 | Registered flag: the final stages disagreed at the last edge |

## Verification
A corrupted stage inside one chain reaches that chain's final flip-flop within STAGES edges of the upset. It then shows on `mismatch_o` one edge later. The voted outputs, by contrast, stay correct while only one copy is wrong. A missing or extra stage shows at the ports immediately, as output that is one edge early or late in the latency sweep. To emulate an upset, the bench overrides one or two final-stage taps. It then checks that the voted value follows the majority and that the flag rises after one edge and falls again after one edge.

// File: rtl/tmr_sync_pkg.sv
package tmr_sync_pkg;

  typedef enum logic {
    TOPO_BLOCK = 1'b0,
    TOPO_DIST  = 1'b1
  } topo_e;

  localparam int unsigned NUM_COPIES = 3;

endpackage

// File: rtl/tmr_sync_chain.sv
module tmr_sync_chain #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  // pure shift path: nothing between flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[LAST];

  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> stage_q[0] == $past(d_i));

  for (genvar s = 1; s < STAGES; s++) begin : g_link
    a_r3_direct_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> stage_q[s] == $past(stage_q[s-1]));
  end

endmodule

// File: rtl/tmr_sync_voter.sv
module tmr_sync_voter #(
  parameter int unsigned WIDTH = 1
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] z_i,
  output logic [WIDTH-1:0] v_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign v_o[b] = (x_i[b] & y_i[b]) | (y_i[b] & z_i[b]) | (x_i[b] & z_i[b]);
  end

endmodule

// File: rtl/tmr_sync_mismatch.sv
module tmr_sync_mismatch #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] z_i,
  output logic             flag_o
);

  logic differ;

  assign differ = (|(x_i ^ y_i)) | (|(y_i ^ z_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= differ;
  end

endmodule

// File: rtl/tmr_cdc_sync.sv
module tmr_cdc_sync
  import tmr_sync_pkg::*;
#(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 3,
  parameter topo_e            TOPO    = TOPO_DIST,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] sync_a_o,
  output logic [WIDTH-1:0] sync_b_o,
  output logic [WIDTH-1:0] sync_c_o,
  output logic             mismatch_o
);

  // final-stage values seen by the voters
  logic [WIDTH-1:0] tap0_w, tap1_w, tap2_w;

  // R9: filter needs capture plus at least one protection stage
  if (STAGES < 2) begin : g_bad_stages
    $error("tmr_cdc_sync: STAGES must be at least 2");
  end

  if (TOPO == TOPO_BLOCK) begin : g_block
    logic [WIDTH-1:0] shared_w;

    tmr_sync_chain #(
      .WIDTH  (WIDTH),
      .STAGES (STAGES),
      .RST_VAL(RST_VAL)
    ) u_chain (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (data_i),
      .q_o   (shared_w)
    );

    assign tap0_w = shared_w;
    assign tap1_w = shared_w;
    assign tap2_w = shared_w;
  end else begin : g_dist
    logic [WIDTH-1:0] fin_w [NUM_COPIES];

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
      tmr_sync_chain #(
        .WIDTH  (WIDTH),
        .STAGES (STAGES),
        .RST_VAL(RST_VAL)
      ) u_chain (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (data_i),
        .q_o   (fin_w[c])
      );
    end

    assign tap0_w = fin_w[0];
    assign tap1_w = fin_w[1];
    assign tap2_w = fin_w[2];
  end

  // voting only after the last stage
  tmr_sync_voter #(.WIDTH(WIDTH)) u_vote_a (
    .x_i(tap0_w), .y_i(tap1_w), .z_i(tap2_w), .v_o(sync_a_o)
  );

  tmr_sync_voter #(.WIDTH(WIDTH)) u_vote_b (
    .x_i(tap0_w), .y_i(tap1_w), .z_i(tap2_w), .v_o(sync_b_o)
  );

  tmr_sync_voter #(.WIDTH(WIDTH)) u_vote_c (
    .x_i(tap0_w), .y_i(tap1_w), .z_i(tap2_w), .v_o(sync_c_o)
  );

  tmr_sync_mismatch #(.WIDTH(WIDTH)) u_mismatch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (tap0_w),
    .y_i   (tap1_w),
    .z_i   (tap2_w),
    .flag_o(mismatch_o)
  );

  a_r6_pair_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap0_w == tap1_w) |-> (sync_a_o == tap0_w && sync_b_o == tap0_w && sync_c_o == tap0_w));

  a_r7_flag_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap0_w != tap1_w || tap1_w != tap2_w) |=> mismatch_o);

  a_r7_flag_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap0_w == tap1_w && tap1_w == tap2_w) |=> !mismatch_o);

endmodule

// File: tb/tmr_cdc_sync_tb.sv
module tmr_cdc_sync_tb;

  localparam int unsigned W   = 4;
  localparam int unsigned S_D = 3;
  localparam int unsigned S_B = 2;
  localparam logic [W-1:0] RV_D = 4'h6;
  localparam logic [W-1:0] RV_B = 4'h0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] din = '0;

  logic [W-1:0] d_a, d_b, d_c, b_a, b_b, b_c;
  logic d_mm, b_mm;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tmr_cdc_sync #(
    .WIDTH(W), .STAGES(S_D), .TOPO(tmr_sync_pkg::TOPO_DIST), .RST_VAL(RV_D)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din),
    .sync_a_o(d_a), .sync_b_o(d_b), .sync_c_o(d_c), .mismatch_o(d_mm)
  );

  tmr_cdc_sync #(
    .WIDTH(W), .STAGES(S_B), .TOPO(tmr_sync_pkg::TOPO_BLOCK), .RST_VAL(RV_B)
  ) u_blk (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din),
    .sync_a_o(b_a), .sync_b_o(b_b), .sync_c_o(b_c), .mismatch_o(b_mm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] gray(input int unsigned i);
    logic [W-1:0] v = W'(i);
    return v ^ (v >> 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] oldv, newv;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 dist reset", {d_a, d_b, d_c, 3'b0, d_mm}, {RV_D, RV_D, RV_D, 4'h0});
    chk("R8 blk reset", {b_a, b_b, b_c, 3'b0, b_mm}, {RV_B, RV_B, RV_B, 4'h0});
    rst_n = 1'b1;
    repeat (4) step();
    chk("R2 settle dist", {d_a, d_b, d_c}, 12'h000);

    // R2/R4/R5 latency sweep over all gray-coded values
    for (int i = 1; i <= 16; i++) begin
      oldv = gray(i - 1);
      newv = gray(i % 16);
      din = newv;
      for (int n = 1; n <= 4; n++) begin
        step();
        chk("R2 R5 dist latency", {d_a, d_b, d_c},
            (n >= int'(S_D)) ? {newv, newv, newv} : {oldv, oldv, oldv});
        chk("R2 R4 blk latency", {b_a, b_b, b_c},
            (n >= int'(S_B)) ? {newv, newv, newv} : {oldv, oldv, oldv});
        chk("R7 no mismatch", {d_mm, b_mm}, 2'b00);
      end
    end

    // R1 glitch between edges is not sampled
    din = 4'h3;
    #2 din = 4'h0;
    for (int n = 1; n <= 4; n++) begin
      step();
      chk("R1 glitch ignored", {d_a, d_b, d_c, b_a, b_b, b_c}, 24'h0);
    end

    // R6/R7 single-copy upset on each tap
    din = 4'hA;
    repeat (4) step();
    for (int t = 0; t < 3; t++) begin
      case (t)
        0: force u_dut.tap0_w = 4'h5;
        1: force u_dut.tap1_w = 4'h5;
        default: force u_dut.tap2_w = 4'h5;
      endcase
      #1;
      chk("R6 single upset masked", {d_a, d_b, d_c}, 12'hAAA);
      chk("R7 flag before edge", {31'h0, d_mm}, 32'h0);
      step();
      chk("R7 flag raised", {31'h0, d_mm}, 32'h1);
      chk("R6 masked after edge", {d_a, d_b, d_c}, 12'hAAA);
      case (t)
        0: release u_dut.tap0_w;
        1: release u_dut.tap1_w;
        default: release u_dut.tap2_w;
      endcase
      step();
      chk("R7 flag cleared", {31'h0, d_mm}, 32'h0);
    end

    // R6 two agreeing wrong copies win
    force u_dut.tap0_w = 4'h5;
    force u_dut.tap2_w = 4'h5;
    #1;
    chk("R6 two copies win", {d_a, d_b, d_c}, 12'h555);
    step();
    chk("R7 flag on double upset", {31'h0, d_mm}, 32'h1);
    release u_dut.tap0_w;
    release u_dut.tap2_w;
    #1;
    chk("R6 restored vote", {d_a, d_b, d_c}, 12'hAAA);
    step();

    // R6/R7 upset on block-mode fan-out
    force u_blk.tap2_w = 4'h0;
    #1;
    chk("R6 blk upset masked", {b_a, b_b, b_c}, 12'hAAA);
    step();
    chk("R7 blk flag raised", {31'h0, b_mm}, 32'h1);
    release u_blk.tap2_w;
    step();
    chk("R7 blk flag cleared", {31'h0, b_mm}, 32'h0);

    // R8 asynchronous mid-cycle reset
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R8 async dist", {d_a, d_b, d_c, 3'b0, d_mm}, {RV_D, RV_D, RV_D, 4'h0});
    chk("R8 async blk", {b_a, b_b, b_c, 3'b0, b_mm}, {RV_B, RV_B, RV_B, 4'h0});
    step();
    chk("R8 held over edge", {d_a, d_b, d_c}, {RV_D, RV_D, RV_D});
    rst_n = 1'b1;
    for (int n = 1; n <= 3; n++) begin
      step();
      chk("R2 R8 recovery dist", {d_a, d_b, d_c},
          (n >= int'(S_D)) ? 12'hAAA : {RV_D, RV_D, RV_D});
      chk("R2 R8 recovery blk", {b_a, b_b, b_c},
          (n >= int'(S_B)) ? 12'hAAA : {RV_B, RV_B, RV_B});
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule